// File: doc/BRIEF.md
# Pin Controller with Edge Capture

This block is a register-mapped controller for a bank of general-purpose pins (28 by default). Software reads the synchronized pin levels and chooses a direction for each pin. It drives output pins through two write-only-style registers: writing ones to one of them raises latch bits, and writing ones to the other lowers them. A pin can also be handed to a peripheral, which then supplies the value the pin drives. The pad itself stays outside the block. It connects through an input vector, an output vector and an output-enable vector.

Each pin has its own rising-edge enable and falling-edge enable. A detected edge sets a sticky status bit, and software clears that bit by writing a one to it. The low pins (0 to 10 by default) each drive their own interrupt line. The remaining pins share one combined line.

Registers sit at word offsets on a byte address. The set and clear registers read back the output latch. The level register is read-only.

Top module: `gpio_edge_unit`

## Requirements
- R1: While reset is asserted and just after it is released, the direction, rise-enable, fall-enable, alternate-select, output latch and edge-status registers are all zero, pin_oe and pin_out are all zero, and no interrupt line is high.
- R2: A read at byte offset 0x00 returns the synchronized pin levels, where 1 means high. A change on pin_in shows up there exactly two rising clock edges after it is applied, and not after one.
- R3: Offset 0x04 holds the direction bits, and it reads back what was written. pin_oe follows these bits one cycle after the write, where 1 means output.
- R4: Writing to offset 0x08 sets every output-latch bit whose data bit is 1 and leaves the other bits alone. Reads of 0x08 and of 0x0C both return the latch.
- R5: Writing to offset 0x0C clears every output-latch bit whose data bit is 1 and leaves the other bits alone.
- R6: Offset 0x10 holds the per-pin rising enables and offset 0x14 the falling enables. A synchronized 0-to-1 change on a pin with its rising enable set captures an edge, and so does a 1-to-0 change on a pin with its falling enable set. With both enables set, either direction captures. With neither set, nothing is captured.
- R7: The edge-status bits at offset 0x18 stay set until software writes a 1 to that bit. Writing a 0 leaves the bit unchanged.
- R8: If a new edge is captured in the same cycle that a write of 1 clears that status bit, the bit remains set.
- R9: Offset 0x1C holds the alternate-select bits. A pin with the bit at 1 drives alt_out on pin_out, and a pin with the bit at 0 drives its output-latch bit.
- R10: irq_pin[i] equals status bit i for each pin below NDIRECT. irq_shared is high exactly when any status bit from NDIRECT upward is set.
- R11: Writes to offset 0x00 and writes whose address is not word-aligned change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | NPINS | Write data, one bit per pin |
| bus_rdata | output | NPINS | Read data for bus_addr, combinational |
| pin_in | input | NPINS | Raw pin levels from the pads |
| alt_out | input | NPINS | Values from peripherals for pins in alternate mode |
| pin_out | output | NPINS | Value each pin drives |
| pin_oe | output | NPINS | Output enable per pin |
| irq_pin | output | NDIRECT | Dedicated interrupt per low pin |
| irq_shared | output | 1 | Combined interrupt for the upper pins |

## Verification
The bench builds the block with its default parameters: 28 pins, 11 dedicated interrupt lines and a two-stage synchronizer. These values give both interrupt groups real width, and they put pin 10 and pin 11 on opposite sides of the split. A fixed synchronizer depth gives exact latencies, so the bench can probe the level one edge too early. It can also place a clearing write in the very cycle an edge is captured. Random enable patterns, pin flips and partial clears run against a status model kept in the bench.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

   localparam int GPIO_ADDR_W = 5;

   typedef enum logic [2:0] {
      RG_LEVEL = 3'd0,
      RG_DIR   = 3'd1,
      RG_SET   = 3'd2,
      RG_CLR   = 3'd3,
      RG_RISE  = 3'd4,
      RG_FALL  = 3'd5,
      RG_STAT  = 3'd6,
      RG_ALT   = 3'd7
   } gpio_reg_e;

   function automatic logic addr_aligned(input logic [GPIO_ADDR_W-1:0] a);
      return a[1:0] == 2'b00;
   endfunction

   function automatic gpio_reg_e addr_to_reg(input logic [GPIO_ADDR_W-1:0] a);
      return gpio_reg_e'(a[GPIO_ADDR_W-1:2]);
   endfunction

endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
   parameter int W      = 28,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_edge_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) chain[k] <= '0;
      end else begin
         chain[0] <= d;
         for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
   parameter int W = 28
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   input  logic [W-1:0] rise_en,
   input  logic [W-1:0] fall_en,
   input  logic [W-1:0] clr,
   output logic [W-1:0] status
);
   for (genvar i = 0; i < W; i++) begin : g_pin
      logic prev_q;
      logic stat_q;
      logic hit;

      assign hit = (rise_en[i] & lvl[i] & ~prev_q) |
                   (fall_en[i] & ~lvl[i] & prev_q);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q <= 1'b0;
            stat_q <= 1'b0;
         end else begin
            prev_q <= lvl[i];
            // a fresh capture outranks a clearing write
            stat_q <= hit | (stat_q & ~clr[i]);
         end
      end

      assign status[i] = stat_q;
   end
endmodule

// File: rtl/gpio_edge_regs.sv
module gpio_edge_regs
   import gpio_edge_pkg::*;
#(
   parameter int NPINS = 28
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_wr,
   input  logic [GPIO_ADDR_W-1:0] bus_addr,
   input  logic [NPINS-1:0]       bus_wdata,
   input  logic [NPINS-1:0]       level,
   input  logic [NPINS-1:0]       status,
   output logic [NPINS-1:0]       dir_q,
   output logic [NPINS-1:0]       rise_q,
   output logic [NPINS-1:0]       fall_q,
   output logic [NPINS-1:0]       alt_q,
   output logic [NPINS-1:0]       out_q,
   output logic [NPINS-1:0]       stat_clr,
   output logic [NPINS-1:0]       bus_rdata
);
   logic      ok;
   gpio_reg_e sel;

   assign ok  = addr_aligned(bus_addr);
   assign sel = addr_to_reg(bus_addr);

   logic wr_dir, wr_set, wr_clr, wr_rise, wr_fall, wr_stat, wr_alt;
   assign wr_dir  = bus_wr && ok && sel == RG_DIR;
   assign wr_set  = bus_wr && ok && sel == RG_SET;
   assign wr_clr  = bus_wr && ok && sel == RG_CLR;
   assign wr_rise = bus_wr && ok && sel == RG_RISE;
   assign wr_fall = bus_wr && ok && sel == RG_FALL;
   assign wr_stat = bus_wr && ok && sel == RG_STAT;
   assign wr_alt  = bus_wr && ok && sel == RG_ALT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         rise_q <= '0;
         fall_q <= '0;
         alt_q  <= '0;
      end else begin
         if (wr_dir)  dir_q  <= bus_wdata;
         if (wr_rise) rise_q <= bus_wdata;
         if (wr_fall) fall_q <= bus_wdata;
         if (wr_alt)  alt_q  <= bus_wdata;
      end
   end

   // output latch: only ever moved by set/clear strobes, bit by bit
   for (genvar i = 0; i < NPINS; i++) begin : g_latch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        out_q[i] <= 1'b0;
         else if (wr_set && bus_wdata[i])   out_q[i] <= 1'b1;
         else if (wr_clr && bus_wdata[i])   out_q[i] <= 1'b0;
      end
   end

   assign stat_clr = wr_stat ? bus_wdata : '0;

   always_comb begin
      bus_rdata = '0;
      if (ok) begin
         unique case (sel)
            RG_LEVEL:       bus_rdata = level;
            RG_DIR:         bus_rdata = dir_q;
            RG_SET, RG_CLR: bus_rdata = out_q;
            RG_RISE:        bus_rdata = rise_q;
            RG_FALL:        bus_rdata = fall_q;
            RG_STAT:        bus_rdata = status;
            RG_ALT:         bus_rdata = alt_q;
            default:        bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
   parameter int NPINS   = 28,
   parameter int NDIRECT = 11
) (
   input  logic [NPINS-1:0]   status,
   output logic [NDIRECT-1:0] irq_pin,
   output logic               irq_shared
);
   for (genvar i = 0; i < NDIRECT; i++) begin : g_direct
      assign irq_pin[i] = status[i];
   end

   if (NDIRECT < NPINS) begin : g_shared
      assign irq_shared = |status[NPINS-1:NDIRECT];
   end else begin : g_no_shared
      assign irq_shared = 1'b0;
   end
endmodule

// File: rtl/gpio_edge_unit.sv
module gpio_edge_unit
   import gpio_edge_pkg::*;
#(
   parameter int NPINS       = 28,
   parameter int NDIRECT     = 11,
   parameter int SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_wr,
   input  logic [GPIO_ADDR_W-1:0] bus_addr,
   input  logic [NPINS-1:0]       bus_wdata,
   output logic [NPINS-1:0]       bus_rdata,
   input  logic [NPINS-1:0]       pin_in,
   input  logic [NPINS-1:0]       alt_out,
   output logic [NPINS-1:0]       pin_out,
   output logic [NPINS-1:0]       pin_oe,
   output logic [NDIRECT-1:0]     irq_pin,
   output logic                   irq_shared
);
   if (NPINS < 1 || NPINS > 32) begin : g_bad_npins
      $error("gpio_edge_unit: NPINS must lie in 1..32");
   end
   if (NDIRECT < 1 || NDIRECT > NPINS) begin : g_bad_ndirect
      $error("gpio_edge_unit: NDIRECT must lie in 1..NPINS");
   end

   logic [NPINS-1:0] level, status, stat_clr;
   logic [NPINS-1:0] dir_q, rise_q, fall_q, alt_q, out_q;

   gpio_edge_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(level)
   );

   gpio_edge_regs #(.NPINS(NPINS)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .level(level), .status(status),
      .dir_q(dir_q), .rise_q(rise_q), .fall_q(fall_q), .alt_q(alt_q),
      .out_q(out_q), .stat_clr(stat_clr), .bus_rdata(bus_rdata)
   );

   gpio_edge_detect #(.W(NPINS)) u_detect (
      .clk(clk), .rst_n(rst_n), .lvl(level), .rise_en(rise_q),
      .fall_en(fall_q), .clr(stat_clr), .status(status)
   );

   gpio_edge_irq #(.NPINS(NPINS), .NDIRECT(NDIRECT)) u_irq (
      .status(status), .irq_pin(irq_pin), .irq_shared(irq_shared)
   );

   for (genvar i = 0; i < NPINS; i++) begin : g_pad
      assign pin_out[i] = alt_q[i] ? alt_out[i] : out_q[i];
   end
   assign pin_oe = dir_q;
endmodule

// File: rtl/gpio_edge_unit_chk.sv
module gpio_edge_unit_chk #(
   parameter int NPINS   = 28,
   parameter int NDIRECT = 11
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_wr,
   input logic [4:0]         bus_addr,
   input logic [NPINS-1:0]   bus_wdata,
   input logic [NPINS-1:0]   pin_oe,
   input logic [NDIRECT-1:0] irq_pin,
   input logic [NPINS-1:0]   out_q,
   input logic [NPINS-1:0]   rise_q,
   input logic [NPINS-1:0]   fall_q
);
   logic w_dir, w_set, w_clr, w_stat;
   assign w_dir  = bus_wr && bus_addr == 5'h04;
   assign w_set  = bus_wr && bus_addr == 5'h08;
   assign w_clr  = bus_wr && bus_addr == 5'h0C;
   assign w_stat = bus_wr && bus_addr == 5'h18;

   AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      w_dir |=> pin_oe == $past(bus_wdata)); // R3

   AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      w_set |=> (out_q & $past(bus_wdata)) == $past(bus_wdata)); // R4

   AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
      w_clr |=> (out_q & $past(bus_wdata)) == '0); // R5

   for (genvar i = 0; i < NDIRECT; i++) begin : g_irq
      AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (irq_pin[i] && !(w_stat && bus_wdata[i])) |=> irq_pin[i]); // R7

      AST_EDGE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq_pin[i]) |-> ($past(rise_q[i]) || $past(fall_q[i]))); // R6
   end
endmodule

bind gpio_edge_unit gpio_edge_unit_chk #(.NPINS(NPINS), .NDIRECT(NDIRECT)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .pin_oe(pin_oe), .irq_pin(irq_pin),
   .out_q(out_q), .rise_q(rise_q), .fall_q(fall_q)
);

// File: tb/gpio_edge_unit_test.sv
`timescale 1ns/1ps
module gpio_edge_unit_test;
   localparam int N   = 28;
   localparam int ND  = 11;
   localparam int SYN = 2;
   localparam logic [4:0] A_LVL = 5'h00, A_DIR = 5'h04, A_SET = 5'h08, A_CLR = 5'h0C,
                          A_RISE = 5'h10, A_FALL = 5'h14, A_STAT = 5'h18, A_ALT = 5'h1C;

   logic clk = 0, rst_n = 0, bus_wr = 0;
   logic [4:0] bus_addr = '0;
   logic [N-1:0] bus_wdata = '0, pin_in = '0, alt_out = '0;
   logic [N-1:0] bus_rdata, pin_out, pin_oe;
   logic [ND-1:0] irq_pin;
   logic irq_shared;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   gpio_edge_unit #(.NPINS(N), .NDIRECT(ND), .SYNC_STAGES(SYN)) uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .alt_out(alt_out), .pin_out(pin_out), .pin_oe(pin_oe),
      .irq_pin(irq_pin), .irq_shared(irq_shared)
   );

   always #2 clk = ~clk;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [N-1:0] d);
      @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [N-1:0] d);
      bus_addr = a; #1 d = bus_rdata;
   endtask

   task automatic drive_pins(input logic [N-1:0] v);
      @(negedge clk); pin_in = v;
      repeat (SYN + 1) @(negedge clk);
   endtask

   function automatic logic [N-1:0] pad_model(input logic [N-1:0] alt, input logic [N-1:0] ao,
                                                input logic [N-1:0] lat);
      return (alt & ao) | (~alt & lat);
   endfunction

   function automatic logic [N-1:0] capture(input logic [N-1:0] r, input logic [N-1:0] f,
                                              input logic [N-1:0] o, input logic [N-1:0] n);
      return (r & ~o & n) | (f & o & ~n);
   endfunction

   logic [N-1:0] rv, latch, exp_stat, cur, dir_v, alt_v;

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h1234_5a5a));
      repeat (3) @(negedge clk);
      // R1: reset state, checked during and after reset
      check("R1 oe in reset", 32'(pin_oe), 0);
      rst_n = 1;
      @(negedge clk);
      rd(A_DIR, rv);  check("R1 dir", 32'(rv), 0);
      rd(A_RISE, rv); check("R1 rise", 32'(rv), 0);
      rd(A_FALL, rv); check("R1 fall", 32'(rv), 0);
      rd(A_ALT, rv);  check("R1 alt", 32'(rv), 0);
      rd(A_SET, rv);  check("R1 latch", 32'(rv), 0);
      rd(A_STAT, rv); check("R1 status", 32'(rv), 0);
      check("R1 pin_out", 32'(pin_out), 0);
      check("R1 irq", {20'd0, irq_shared, irq_pin}, 0);

      // R2: level latency exactly SYN edges
      @(negedge clk); pin_in = 28'h5a5_c3a1;
      @(negedge clk); rd(A_LVL, rv); check("R2 level early", 32'(rv), 0);
      @(negedge clk); rd(A_LVL, rv); check("R2 level", 32'(rv), 32'h5a5_c3a1);
      drive_pins('0); cur = '0;

      // R3: direction
      for (int k = 0; k < 4; k++) begin
         dir_v = N'($urandom);
         wr(A_DIR, dir_v);
         check("R3 pin_oe", 32'(pin_oe), 32'(dir_v));
         rd(A_DIR, rv); check("R3 readback", 32'(rv), 32'(dir_v));
      end

      // R4 / R5: set and clear registers
      latch = '0;
      for (int k = 0; k < 12; k++) begin
         rv = N'($urandom);
         if (k % 2 == 0) begin wr(A_SET, rv); latch |= rv; end
         else begin wr(A_CLR, rv); latch &= ~rv; end
         check(k % 2 == 0 ? "R4 set pin_out" : "R5 clear pin_out", 32'(pin_out), 32'(latch));
         rd(k % 2 == 0 ? A_CLR : A_SET, rv);
         check("R4 latch readback", 32'(rv), 32'(latch));
      end
      wr(A_SET, '1); latch = '1; wr(A_CLR, 28'h000_0001); latch = 28'hfff_fffe;
      check("R5 clear bit0 only", 32'(pin_out), 32'(latch));

      // R9: alternate select
      for (int k = 0; k < 4; k++) begin
         alt_v = N'($urandom);
         alt_out = N'($urandom);
         wr(A_ALT, alt_v);
         check("R9 pin_out mux", 32'(pin_out), 32'(pad_model(alt_v, alt_out, latch)));
      end
      wr(A_ALT, '0);

      // R11: level writes and misaligned writes are ignored
      rd(A_DIR, dir_v);
      wr(A_LVL, '1);
      wr(5'h05, ~dir_v);
      wr(5'h0B, '1);
      rd(A_LVL, rv); check("R11 level", 32'(rv), 0);
      rd(A_DIR, rv); check("R11 dir kept", 32'(rv), 32'(dir_v));
      check("R11 latch kept", 32'(pin_out), 32'(latch));
      rd(A_RISE, rv); check("R11 rise kept", 32'(rv), 0);

      // R6 directed: both enables on bit 3, none on bit 4
      exp_stat = '0;
      wr(A_RISE, 28'h000_0008); wr(A_FALL, 28'h000_0008);
      drive_pins(28'h000_0018); rd(A_STAT, rv); check("R6 rise both", 32'(rv), 32'h8);
      wr(A_STAT, 28'h000_0008);
      drive_pins(28'h000_0000); rd(A_STAT, rv); check("R6 fall both", 32'(rv), 32'h8);
      wr(A_STAT, '1); cur = '0;
      rd(A_STAT, rv); check("R7 clear all", 32'(rv), 0);

      // R8: edge in the clearing cycle keeps the bit
      wr(A_RISE, 28'h000_0001);
      drive_pins(28'h000_0001);                // status bit 0 set
      drive_pins(28'h000_0000);                // no fall enable, stays set
      @(negedge clk); pin_in = 28'h000_0001;
      @(negedge clk);
      @(negedge clk); bus_wr = 1; bus_addr = A_STAT; bus_wdata = 28'h000_0001;
      @(negedge clk); bus_wr = 0; bus_wdata = '0;
      rd(A_STAT, rv); check("R8 edge beats clear", 32'(rv), 32'h1);
      wr(A_STAT, 28'h000_0001);
      rd(A_STAT, rv); check("R7 later clear", 32'(rv), 0);
      cur = 28'h000_0001;

      // R6 / R7 / R10: random enables, pin flips and partial clears
      exp_stat = '0;
      for (int it = 0; it < 80; it++) begin
         logic [N-1:0] r, f, nv, c;
         r = N'($urandom); f = N'($urandom);
         if (it % 5 == 0) r = '0;
         if (it % 7 == 0) f = '0;
         wr(A_RISE, r); wr(A_FALL, f);
         nv = cur ^ N'($urandom & $urandom);
         drive_pins(nv);
         exp_stat |= capture(r, f, cur, nv);
         cur = nv;
         rd(A_STAT, rv); check("R6 status capture", 32'(rv), 32'(exp_stat));
         check("R10 irq_pin", 32'(irq_pin), 32'(exp_stat[ND-1:0]));
         check("R10 irq_shared", 32'(irq_shared), 32'(|exp_stat[N-1:ND]));
         c = N'($urandom);
         if (it % 3 == 0) c = '0;
         wr(A_STAT, c);
         exp_stat &= ~c;
         rd(A_STAT, rv); check("R7 partial clear", 32'(rv), 32'(exp_stat));
      end

      // R10 boundary: pin 10 direct, pin 11 shared
      wr(A_STAT, '1); wr(A_RISE, 28'h000_0c00); wr(A_FALL, '0);
      drive_pins(cur & ~28'h000_0c00);
      wr(A_STAT, '1);
      cur = cur & ~28'h000_0c00;
      drive_pins(cur | 28'h000_0800);
      check("R10 pin11 shared", 32'(irq_shared), 1);
      check("R10 pin11 not direct", 32'(irq_pin), 0);
      drive_pins(cur | 28'h000_0c00);
      check("R10 pin10 direct", 32'(irq_pin), 32'h400);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule